// File: doc/BRIEF.md
# Modular-Exponentiation Accelerator Control Register Bank

This block is the software-facing control point of a modular-exponentiation accelerator. A simple 32-bit word register port with one-cycle reads and writes reaches two locations. The first is a read/write control word. It drives the accelerator's pipeline-part select, its destination and source operand selects, its operating mode and a one-cycle start pulse. The same word also shows four sticky event flags that the datapath raises: done, memory write collision, FIFO full and FIFO push error. The second location is a write-only soft reset. Writing the key value 0x0000000A to it holds the whole core in reset for a fixed 16-cycle window.

Fields use big-endian bit numbering: bit 0 is the most significant bit of the 32-bit word, so bit k sits at vector index 31-k. The combined event level feeds an interrupt controller. Software then reads the control word to find out which event fired, and clears that flag by writing a 0 to it.

Top module: `mexp_ctrl_regs`

## Requirements
- R1: While `rst_n` is low and on the first read after it rises, every control output is 0, `start_pulse` and `event_irq` are 0, and the control word (byte offset 0x000) reads 0x00000000. `core_rst_n` is low while `rst_n` is low.
- R2: A write to offset 0x000 stores the following fields, which read back unchanged and drive the matching outputs on the cycle after the write:
  - pipeline-part select at word bits [31:30] (big-endian bits 0-1; 01 lower, 10 higher, 11 full, 00 invalid);
  - destination operand at [29:28];
  - x operand at [27:26];
  - y operand at [25:24];
  - mode at [22] (big-endian bit 9; 0 single multiplication, 1 exponentiation).
- R3: A control write with bit [23] set (big-endian bit 8) and a non-zero pipeline select raises `start_pulse` for exactly one cycle, in the cycle after the write. Bit [23] always reads 0.
- R4: A control write with bit [23] set and pipeline select 00 gives no start pulse, but its fields are still stored.
- R5: An event input that is high at a clock edge sets its sticky flag. The flags read back at word bits [15] done, [14] memory collision, [13] FIFO full and [12] FIFO push error (big-endian bits 16-19). A flag stays set until software clears it.
- R6: A control write with 0 in a flag's bit clears that flag. A 1 in that bit leaves the flag unchanged.
- R7: When an event and a software clear of the same flag fall on the same edge, the flag ends up set.
- R8: `event_irq` is high exactly when at least one of the four flags is set.
- R9: Writing exactly 0x0000000A to offset 0x100 drives `core_rst_n` low for exactly 16 cycles, starting in the cycle after the write. It returns every control field and every flag to 0.
- R10: Any other value written to offset 0x100 has no effect. Offset 0x100 and all unmapped offsets read 0.
- R11: Unimplemented control bits ([21:16] and [11:0]) read 0 whatever was written to them.
- R12: Read data appears on `reg_rdata` in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, synchronous, active low |
| reg_wr | input | 1 | Write strobe, one cycle per word |
| reg_rd | input | 1 | Read strobe, one cycle per word |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| ev_done | input | 1 | Datapath finished an operation |
| ev_mem_collide | input | 1 | Operand memory write collision |
| ev_fifo_full | input | 1 | FIFO became full |
| ev_fifo_push_err | input | 1 | FIFO push error |
| core_rst_n | output | 1 | Combined core reset (bus or soft), active low |
| pipe_sel | output | 2 | Pipeline-part select |
| dest_op | output | 2 | Destination operand select |
| x_op | output | 2 | x operand select |
| y_op | output | 2 | y operand select |
| exp_mode | output | 1 | 1 = exponentiation mode |
| start_pulse | output | 1 | One-cycle start to the datapath |
| event_irq | output | 1 | OR of the four sticky flags |

## Verification
The bench aims at the corner cases of this block:
- A start with pipeline select 00. A design that ignored the rule would pulse the datapath with an invalid configuration.
- A flag event on the same edge as a software clear of that flag. A design where the clear wins loses the event, and the interrupt with it.
- A soft reset written with a value other than the key. A design that decodes loosely would reset the core by accident.
- The key value itself. The bench counts the low cycles of the core reset, so a window that is off by one shows up in the count.
- Junk written to the unimplemented bits, and reads of bit 8. Either would leak into read data if the readback were built wrongly.

// File: rtl/mexp_ctrl_pkg.sv
// Package: shared constants and types for the accelerator control register bank.
// Assumes 32-bit data words and byte offsets on the register port.
package mexp_ctrl_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 12;
    localparam int NUM_FLAGS   = 4;
    localparam int SRST_CYCLES = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SRST = 12'h100;
    localparam logic [DATA_W-1:0] SRST_KEY = 32'h0000_000A;

    // Vector index of big-endian bit k is DATA_W-1-k.
    localparam int PSEL_HI  = DATA_W - 1;   // big-endian bits 0-1
    localparam int DEST_HI  = DATA_W - 3;   // bits 2-3
    localparam int XOP_HI   = DATA_W - 5;   // bits 4-5
    localparam int YOP_HI   = DATA_W - 7;   // bits 6-7
    localparam int START_IX = DATA_W - 9;   // bit 8
    localparam int MODE_IX  = DATA_W - 10;  // bit 9
    localparam int FLAG_HI  = DATA_W - 17;  // bits 16-19, done first
    localparam int FLAG_LO  = FLAG_HI - NUM_FLAGS + 1;

    localparam logic [1:0] PSEL_INVALID = 2'b00;

    typedef struct packed {
        logic [1:0] psel;
        logic [1:0] dest;
        logic [1:0] xop;
        logic [1:0] yop;
        logic       mode;
    } ctrl_fields_t;
endpackage

// File: rtl/mexp_soft_reset.sv
// Module: soft-reset stretcher. When triggered, holds 'active' high for
// CYCLES clock cycles. Assumes the trigger is a single-cycle qualified strobe.
// Triggers that arrive while a window is running are ignored.
module mexp_soft_reset #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    // Down-counter: loads on trigger, runs to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (trig) begin
            cnt_q <= LOAD;
        end
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/mexp_ctrl_fields.sv
// Module: control field storage and start pulse generation.
// Assumes wr_en is already qualified by address decode and reset state.
module mexp_ctrl_fields
    import mexp_ctrl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  ctrl_fields_t fields_in,
    input  logic         start_in,
    output ctrl_fields_t fields_q,
    output logic         start_pulse
);
    // Field register: captured on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (wr_en) begin
            fields_q <= fields_in;
        end
    end

    // Start pulse: one cycle, only when the new select is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= wr_en && start_in && (fields_in.psel != PSEL_INVALID);
        end
    end
endmodule

// File: rtl/mexp_event_flags.sv
// Module: sticky event flags. Hardware sets, software clears by writing 0.
// A set on the same edge as a clear wins. 'any' is the OR of all flags.
module mexp_event_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags,
    output logic         any
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Per-flag sticky bit with set priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set[i]) begin
                flags[i] <= 1'b1;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

    assign any = |flags;
endmodule

// File: rtl/mexp_ctrl_regs.sv
// Module: top of the accelerator control register bank. Decodes the word
// register port, owns the registered read path, and combines bus and soft
// reset. Assumes word-aligned accesses and at most one strobe per cycle.
module mexp_ctrl_regs
    import mexp_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_done,
    input  logic              ev_mem_collide,
    input  logic              ev_fifo_full,
    input  logic              ev_fifo_push_err,
    output logic              core_rst_n,
    output logic [1:0]        pipe_sel,
    output logic [1:0]        dest_op,
    output logic [1:0]        x_op,
    output logic [1:0]        y_op,
    output logic              exp_mode,
    output logic              start_pulse,
    output logic              event_irq
);
    logic               sel_ctrl, sel_srst;
    logic               ctrl_wr, srst_trig, srst_active;
    ctrl_fields_t       fields_in, fields_q;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
    logic [DATA_W-1:0]  ctrl_word;

    // Address decode and write qualification.
    assign sel_ctrl  = (reg_addr == OFS_CTRL);
    assign sel_srst  = (reg_addr == OFS_SRST);
    assign ctrl_wr   = reg_wr && sel_ctrl && core_rst_n;
    assign srst_trig = reg_wr && sel_srst && (reg_wdata == SRST_KEY);

    assign core_rst_n = rst_n && !srst_active;

    mexp_soft_reset #(.CYCLES(SRST_CYCLES)) u_srst (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (srst_trig),
        .active (srst_active)
    );

    // Unpack control fields from the write word.
    assign fields_in.psel = reg_wdata[PSEL_HI -: 2];
    assign fields_in.dest = reg_wdata[DEST_HI -: 2];
    assign fields_in.xop  = reg_wdata[XOP_HI  -: 2];
    assign fields_in.yop  = reg_wdata[YOP_HI  -: 2];
    assign fields_in.mode = reg_wdata[MODE_IX];

    mexp_ctrl_fields u_fields (
        .clk         (clk),
        .rst_n       (core_rst_n),
        .wr_en       (ctrl_wr),
        .fields_in   (fields_in),
        .start_in    (reg_wdata[START_IX]),
        .fields_q    (fields_q),
        .start_pulse (start_pulse)
    );

    // Flag index 0 = done at the highest flag bit, down to push error.
    assign flag_set = {ev_fifo_push_err, ev_fifo_full, ev_mem_collide, ev_done};
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
        assign flag_clr[i] = ctrl_wr && !reg_wdata[FLAG_HI - i];
    end

    mexp_event_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (core_rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flag_q),
        .any   (event_irq)
    );

    // Readback word assembly; start and unimplemented bits read 0.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[PSEL_HI -: 2] = fields_q.psel;
        ctrl_word[DEST_HI -: 2] = fields_q.dest;
        ctrl_word[XOP_HI  -: 2] = fields_q.xop;
        ctrl_word[YOP_HI  -: 2] = fields_q.yop;
        ctrl_word[MODE_IX]      = fields_q.mode;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            ctrl_word[FLAG_HI - i] = flag_q[i];
        end
    end

    // Registered read data, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd && sel_ctrl) begin
            reg_rdata <= ctrl_word;
        end else begin
            reg_rdata <= '0;
        end
    end

    assign pipe_sel = fields_q.psel;
    assign dest_op  = fields_q.dest;
    assign x_op     = fields_q.xop;
    assign y_op     = fields_q.yop;
    assign exp_mode = fields_q.mode;
endmodule

// File: rtl/mexp_ctrl_regs_chk.sv
// Module: assertion checker for mexp_ctrl_regs, attached with bind.
// Assumes the flag order of the top: index 0 = done.
module mexp_ctrl_regs_chk
    import mexp_ctrl_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 core_rst_n,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic                 start_pulse,
    input logic [1:0]           pipe_sel,
    input logic                 ev_done,
    input logic [NUM_FLAGS-1:0] flag_q
);
    logic [7:0] low_cnt;

    // Counts consecutive cycles of soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || core_rst_n) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(reg_wr && reg_addr == OFS_CTRL && reg_wdata[START_IX]
                              && reg_wdata[PSEL_HI -: 2] != PSEL_INVALID)); // R3
    AST_NO_START_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |-> !start_pulse); // R9
    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_n && ev_done) |=> flag_q[0]); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_n && flag_q[0] && !(reg_wr && reg_addr == OFS_CTRL && !reg_wdata[FLAG_HI]))
        |=> flag_q[0]); // R5
    AST_PSEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_n && !(reg_wr && reg_addr == OFS_CTRL)) |=> $stable(pipe_sel)); // R2
    AST_SRST_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= 8'(SRST_CYCLES)); // R9
endmodule

bind mexp_ctrl_regs mexp_ctrl_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_rst_n  (core_rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .start_pulse (start_pulse),
    .pipe_sel    (pipe_sel),
    .ev_done     (ev_done),
    .flag_q      (flag_q)
);

// File: tb/mexp_ctrl_regs_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard for mexp_ctrl_regs. Read tasks queue expected words;
// a monitor pops and compares them when read data appears.
module mexp_ctrl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_done = 1'b0, ev_mem_collide = 1'b0, ev_fifo_full = 1'b0, ev_fifo_push_err = 1'b0;
    logic        core_rst_n, exp_mode, start_pulse, event_irq;
    logic [1:0]  pipe_sel, dest_op, x_op, y_op;

    int checks = 0, errors = 0, cycles = 0;
    logic rd_seen = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    mexp_ctrl_regs u_mexp_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_done(ev_done), .ev_mem_collide(ev_mem_collide),
        .ev_fifo_full(ev_fifo_full), .ev_fifo_push_err(ev_fifo_push_err),
        .core_rst_n(core_rst_n), .pipe_sel(pipe_sel), .dest_op(dest_op),
        .x_op(x_op), .y_op(y_op), .exp_mode(exp_mode),
        .start_pulse(start_pulse), .event_irq(event_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Builds a control word from fields per R2/R3/R5 bit positions.
    function automatic logic [31:0] mk(input logic [1:0] ps, input logic [1:0] d,
            input logic [1:0] x, input logic [1:0] y, input logic st, input logic md,
            input logic [3:0] fl, input logic junk);
        logic [31:0] w;
        w = {ps, d, x, y, st, md, {6{junk}}, fl, {12{junk}}};
        return w;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Monitor: compare read data the cycle after each strobe (R12).
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12: unexpected read data %h expected none", reg_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, reg_rdata, it.exp);
            end
        end
    end

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            finish_run();
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 core_rst_n in reset", 32'(core_rst_n), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pipe_sel", 32'(pipe_sel), 0);
        check("R1 start_pulse", 32'(start_pulse), 0);
        check("R1 event_irq", 32'(event_irq), 0);
        rd(12'h000, 32'h0, "R1 ctrl after reset");

        // R2 / R11: fields with junk in unimplemented bits.
        wr(12'h000, mk(2'b10, 2'b11, 2'b01, 2'b10, 1'b0, 1'b1, 4'b1111, 1'b1));
        check("R2 pipe_sel", 32'(pipe_sel), 2);
        check("R2 dest_op", 32'(dest_op), 3);
        check("R2 x_op", 32'(x_op), 1);
        check("R2 y_op", 32'(y_op), 2);
        check("R2 exp_mode", 32'(exp_mode), 1);
        rd(12'h000, mk(2'b10, 2'b11, 2'b01, 2'b10, 1'b0, 1'b1, 4'b0000, 1'b0), "R11 readback");

        // R3: start pulse.
        wr(12'h000, mk(2'b01, 2'b00, 2'b10, 2'b01, 1'b1, 1'b0, 4'b1111, 1'b0));
        check("R3 start high", 32'(start_pulse), 1);
        @(negedge clk);
        check("R3 start one cycle", 32'(start_pulse), 0);
        rd(12'h000, mk(2'b01, 2'b00, 2'b10, 2'b01, 1'b0, 1'b0, 4'b0000, 1'b0), "R3 bit8 reads 0");

        // R4: start with invalid select.
        wr(12'h000, mk(2'b00, 2'b01, 2'b01, 2'b01, 1'b1, 1'b1, 4'b1111, 1'b0));
        check("R4 no start", 32'(start_pulse), 0);
        check("R4 pipe_sel stored", 32'(pipe_sel), 0);
        check("R4 x_op stored", 32'(x_op), 1);

        // R5 / R8: flags.
        ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
        check("R8 irq after done", 32'(event_irq), 1);
        ev_fifo_full = 1'b1; @(negedge clk); ev_fifo_full = 1'b0;
        repeat (3) @(negedge clk);
        rd(12'h000, mk(2'b00, 2'b01, 2'b01, 2'b01, 1'b0, 1'b1, 4'b1010, 1'b0), "R5 sticky flags");

        // R6: clear done only.
        wr(12'h000, mk(2'b00, 2'b01, 2'b01, 2'b01, 1'b0, 1'b1, 4'b0111, 1'b0));
        rd(12'h000, mk(2'b00, 2'b01, 2'b01, 2'b01, 1'b0, 1'b1, 4'b0010, 1'b0), "R6 clear done");

        // R7: set beats clear on memory collision.
        ev_mem_collide = 1'b1;
        wr(12'h000, mk(2'b00, 2'b01, 2'b01, 2'b01, 1'b0, 1'b1, 4'b1011, 1'b0));
        ev_mem_collide = 1'b0;
        rd(12'h000, mk(2'b00, 2'b01, 2'b01, 2'b01, 1'b0, 1'b1, 4'b0110, 1'b0), "R7 set wins");

        // R5: push error, then clear all; R8 irq drops.
        ev_fifo_push_err = 1'b1; @(negedge clk); ev_fifo_push_err = 1'b0;
        rd(12'h000, mk(2'b00, 2'b01, 2'b01, 2'b01, 1'b0, 1'b1, 4'b0111, 1'b0), "R5 push err flag");
        wr(12'h000, mk(2'b11, 2'b10, 2'b00, 2'b11, 1'b0, 1'b0, 4'b0000, 1'b0));
        check("R8 irq clear", 32'(event_irq), 0);

        // R10: wrong key has no effect; reads of soft reset and unmapped are 0.
        wr(12'h100, 32'h0000_0005);
        check("R10 no reset", 32'(core_rst_n), 1);
        @(negedge clk);
        check("R10 still no reset", 32'(core_rst_n), 1);
        rd(12'h000, mk(2'b11, 2'b10, 2'b00, 2'b11, 1'b0, 1'b0, 4'b0000, 1'b0), "R10 ctrl kept");
        rd(12'h100, 32'h0, "R10 srst reads 0");
        rd(12'h204, 32'h0, "R10 unmapped reads 0");

        // R9: soft reset window of 16 cycles.
        ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
        wr(12'h100, 32'h0000_000A);
        n = 0;
        while (!core_rst_n && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R9 reset length", n, 16);
        check("R9 pipe_sel cleared", 32'(pipe_sel), 0);
        check("R9 irq cleared", 32'(event_irq), 0);
        rd(12'h000, 32'h0, "R9 ctrl cleared");

        repeat (3) @(negedge clk);
        check("R12 queue drained", sb_q.size(), 0);
        finish_run();
    end
endmodule